// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged TLB

This block translates virtual addresses through a small, fully associative table. Every entry carries one tag for a pair of neighbouring pages. That tag is a virtual page number, a per-entry page mask, an address-space identifier (ASID) and a global flag. The entry also holds two page halves. Each half has its own frame number, cache attribute, dirty flag and valid flag.

Software fills the table by naming a slot. There is no replacement policy. A flush input empties the whole table in one cycle.

The block has four access paths:
- A lookup path. It returns a translation one cycle after the request, together with a hit, invalid-half or tag-miss outcome and an uncacheable flag derived from the address.
- A probe path. It answers in the same cycle with the index of the matching slot.
- An indexed write path.
- A statistics port. It selects one of four lookup outcome counters.

Top module: `asid_tlb`

## Requirements
- R1: A slot matches when the stored page number (`wr_hi[11 +: VPN_W]`) equals the looked-up page number (`lk_va[11 +: VPN_W]`) on every bit that is clear in that slot's mask (`wr_mask[11 +: VPN_W]`). Bits set in the mask do not take part in the compare.
- R2: A tag match counts only if the slot is global or the request ASID equals the stored ASID (`wr_hi[ASID_W-1:0]`). A slot that was never written since reset or flush never matches.
- R3: When several slots match, the lowest index is used by both the lookup and the probe.
- R4: `pr_index` gives the index of the first matching slot, zero-extended, in the same cycle. When no slot matches it is all ones.
- R5: A write with `wr_index` greater than or equal to ENTRIES leaves the table unchanged.
- R6: Each page half is written in this layout: frame number from bit 6 up, cache attribute in bits 5:3, dirty at bit 2, valid at bit 1, global at bit 0. A slot is global only when the global bit is set in both halves.
- R7: Let n be the number of set bits in the matched slot's mask (masks are contiguous from bit 0). The half is chosen by `lk_va[10+n]`. The physical address is the chosen frame number shifted left by 10, ORed with the low 10+n bits of `lk_va`.
- R8: A match whose chosen half has its valid flag clear raises `rsp_invalid`, not `rsp_hit`. No match raises `rsp_tag_miss`. Exactly one of the three is high with every response.
- R9: `flush` empties every slot at the next edge and takes priority over a write in the same cycle. It leaves the counters alone.
- R10: `rsp_uncached` is high exactly when bits 31 and 29 of the address are both set, whatever the match outcome.
- R11: `stat_count` shows the counter picked by `stat_sel`: 0 read hits, 1 read misses, 2 write hits, 3 write misses. `lk_write` chooses read or write. Invalid-half and tag-miss outcomes both count as misses. Each counter changes by one per lookup and is cleared only by reset.
- R12: `rsp_valid` rises exactly one cycle after `lk_valid`, so back-to-back lookups give back-to-back responses in order. After reset the table is empty and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a store (counter selection) |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space identifier of the request |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Valid translation found |
| rsp_invalid | output | 1 | Tag matched but chosen half not valid |
| rsp_tag_miss | output | 1 | No slot matched |
| rsp_pa | output | PFN_W+10 | Physical address |
| rsp_cattr | output | 3 | Cache attribute of the chosen half |
| rsp_dirty | output | 1 | Dirty flag of the chosen half |
| rsp_uncached | output | 1 | Address lies in the uncached window |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe ASID |
| pr_index | output | IDX_W+1 | Matching slot, or all ones |
| wr_en | input | 1 | Write a slot |
| wr_index | input | IDX_W+1 | Slot to write |
| wr_hi | input | 11+VPN_W | Page number from bit 11, ASID in low bits |
| wr_mask | input | 11+VPN_W | Page mask from bit 11 |
| wr_lo0 | input | 6+PFN_W | Even half descriptor |
| wr_lo1 | input | 6+PFN_W | Odd half descriptor |
| flush | input | 1 | Empty the whole table |
| stat_sel | input | 2 | Counter select |
| stat_count | output | CNT_W | Selected counter value |

## Verification
The bench builds the block with ENTRIES=8 and CNT_W=8, keeping the default page-number, ASID and frame widths. With eight slots the write index is four bits wide. Indices 8 through 15 then exist on the port and are out of range, so the ignored-write boundary can be driven directly. The probe's no-match code becomes 4'hF, which is distinct from every real index. The default widths keep the 32-bit uncached window and masked pages wider than 1 KB reachable.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // half-descriptor field positions
   localparam int LO_G_BIT    = 0;
   localparam int LO_V_BIT    = 1;
   localparam int LO_D_BIT    = 2;
   localparam int LO_C_LSB    = 3;
   localparam int CATTR_W     = 3;
   localparam int LO_PFN_LSB  = 6;
   // tag-word layout and smallest page
   localparam int HI_VPN_LSB  = 11;
   localparam int PAGE_SHIFT  = 10;

   typedef enum logic [1:0] {
      ST_RD_HIT  = 2'd0,
      ST_RD_MISS = 2'd1,
      ST_WR_HIT  = 2'd2,
      ST_WR_MISS = 2'd3
   } stat_sel_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8
) (
   input  logic              e_used,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [VPN_W-1:0]  e_mask,
   input  logic [ASID_W-1:0] e_asid,
   input  logic              e_global,
   input  logic [VPN_W-1:0]  q_vpn,
   input  logic [ASID_W-1:0] q_asid,
   output logic              match
);
   logic tag_eq;
   logic asid_ok;

   assign tag_eq  = ((q_vpn ^ e_vpn) & ~e_mask) == '0;
   assign asid_ok = e_global | (q_asid == e_asid);
   assign match   = e_used & tag_eq & asid_ok;
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_stats.sv
module tlb_stats
   import tlb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic             ev_write,
   input  logic             ev_hit,
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] cnt
);
   logic [3:0][CNT_W-1:0] cnt_q;
   stat_sel_e             ev_slot;

   always_comb begin
      case ({ev_write, ev_hit})
         2'b01:   ev_slot = ST_RD_HIT;
         2'b00:   ev_slot = ST_RD_MISS;
         2'b11:   ev_slot = ST_WR_HIT;
         default: ev_slot = ST_WR_MISS;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ev_valid) begin
         cnt_q[ev_slot] <= cnt_q[ev_slot] + 1'b1;
      end
   end

   assign cnt = cnt_q[sel];

   // R11
   idle_counts_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> $stable(cnt_q));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 19,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   parameter int VA_W    = 32,
   parameter int CNT_W   = 16,
   parameter logic [VA_W-1:0] UC_PATTERN = 32'hA000_0000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         lk_valid,
   input  logic                         lk_write,
   input  logic [VA_W-1:0]              lk_va,
   input  logic [ASID_W-1:0]            lk_asid,
   output logic                         rsp_valid,
   output logic                         rsp_hit,
   output logic                         rsp_invalid,
   output logic                         rsp_tag_miss,
   output logic [PFN_W+PAGE_SHIFT-1:0]  rsp_pa,
   output logic [CATTR_W-1:0]           rsp_cattr,
   output logic                         rsp_dirty,
   output logic                         rsp_uncached,
   input  logic [VPN_W-1:0]             pr_vpn,
   input  logic [ASID_W-1:0]            pr_asid,
   output logic [$clog2(ENTRIES):0]     pr_index,
   input  logic                         wr_en,
   input  logic [$clog2(ENTRIES):0]     wr_index,
   input  logic [HI_VPN_LSB+VPN_W-1:0]  wr_hi,
   input  logic [HI_VPN_LSB+VPN_W-1:0]  wr_mask,
   input  logic [LO_PFN_LSB+PFN_W-1:0]  wr_lo0,
   input  logic [LO_PFN_LSB+PFN_W-1:0]  wr_lo1,
   input  logic                         flush,
   input  logic [1:0]                   stat_sel,
   output logic [CNT_W-1:0]             stat_count
);
   localparam int IDX_W  = $clog2(ENTRIES);
   localparam int PIDX_W = IDX_W + 1;
   localparam int HI_W   = HI_VPN_LSB + VPN_W;
   localparam int PA_W   = PFN_W + PAGE_SHIFT;
   localparam int POS_W  = $clog2(VA_W);
   localparam logic [PIDX_W-1:0] ENTRIES_V = PIDX_W'(ENTRIES);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("asid_tlb: ENTRIES must be at least 2");
   end
   if (VA_W < HI_W) begin : g_bad_va
      $error("asid_tlb: VA_W too narrow for VPN_W");
   end
   if (ASID_W >= HI_VPN_LSB) begin : g_bad_asid
      $error("asid_tlb: ASID_W must be below the tag page-number field");
   end

   // ---------------- storage ----------------
   logic [ENTRIES-1:0]             t_used;
   logic [ENTRIES-1:0]             t_g;
   logic [VPN_W-1:0]               t_vpn   [ENTRIES];
   logic [VPN_W-1:0]               t_mask  [ENTRIES];
   logic [ASID_W-1:0]              t_asid  [ENTRIES];
   logic [1:0][PFN_W-1:0]          t_pfn   [ENTRIES];
   logic [1:0][CATTR_W-1:0]        t_c     [ENTRIES];
   logic [1:0]                     t_d     [ENTRIES];
   logic [1:0]                     t_v     [ENTRIES];

   logic             wr_ok;
   logic [IDX_W-1:0] wi;
   assign wr_ok = wr_en && (wr_index < ENTRIES_V);
   assign wi    = wr_index[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         t_used <= '0;
         t_g    <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            t_vpn[i]  <= '0;
            t_mask[i] <= '0;
            t_asid[i] <= '0;
            t_pfn[i]  <= '0;
            t_c[i]    <= '0;
            t_d[i]    <= '0;
            t_v[i]    <= '0;
         end
      end else if (wr_ok) begin
         t_used[wi]   <= 1'b1;
         t_g[wi]      <= wr_lo0[LO_G_BIT] & wr_lo1[LO_G_BIT];
         t_vpn[wi]    <= wr_hi[HI_VPN_LSB +: VPN_W];
         t_mask[wi]   <= wr_mask[HI_VPN_LSB +: VPN_W];
         t_asid[wi]   <= wr_hi[ASID_W-1:0];
         t_pfn[wi][0] <= wr_lo0[LO_PFN_LSB +: PFN_W];
         t_pfn[wi][1] <= wr_lo1[LO_PFN_LSB +: PFN_W];
         t_c[wi][0]   <= wr_lo0[LO_C_LSB +: CATTR_W];
         t_c[wi][1]   <= wr_lo1[LO_C_LSB +: CATTR_W];
         t_d[wi]      <= {wr_lo1[LO_D_BIT], wr_lo0[LO_D_BIT]};
         t_v[wi]      <= {wr_lo1[LO_V_BIT], wr_lo0[LO_V_BIT]};
      end
   end

   logic unused_bits;
   assign unused_bits = ^{wr_mask[HI_VPN_LSB-1:0], wr_hi[HI_VPN_LSB-1:ASID_W]};

   // ---------------- match arrays ----------------
   logic [VPN_W-1:0]   lk_vpn;
   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] pr_match;
   assign lk_vpn = lk_va[HI_VPN_LSB +: VPN_W];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
         .e_used  (t_used[e]),
         .e_vpn   (t_vpn[e]),
         .e_mask  (t_mask[e]),
         .e_asid  (t_asid[e]),
         .e_global(t_g[e]),
         .q_vpn   (lk_vpn),
         .q_asid  (lk_asid),
         .match   (lk_match[e])
      );
      tlb_match #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_pr_cmp (
         .e_used  (t_used[e]),
         .e_vpn   (t_vpn[e]),
         .e_mask  (t_mask[e]),
         .e_asid  (t_asid[e]),
         .e_global(t_g[e]),
         .q_vpn   (pr_vpn),
         .q_asid  (pr_asid),
         .match   (pr_match[e])
      );
   end

   logic             lk_found, pr_found;
   logic [IDX_W-1:0] lk_idx, pr_idx;

   tlb_first #(.N(ENTRIES), .IW(IDX_W)) u_lk_first (
      .vec(lk_match), .found(lk_found), .idx(lk_idx));
   tlb_first #(.N(ENTRIES), .IW(IDX_W)) u_pr_first (
      .vec(pr_match), .found(pr_found), .idx(pr_idx));

   assign pr_index = pr_found ? {1'b0, pr_idx} : '1;

   // ---------------- half selection and address ----------------
   logic [VPN_W-1:0]   lk_msk;
   logic [POS_W-1:0]   half_pos;
   logic               lk_half;
   logic [VA_W-1:0]    off_mask;
   logic [PFN_W-1:0]   lk_pfn;
   logic               lk_vld, lk_hit_now;

   always_comb begin
      lk_msk     = t_mask[lk_idx];
      half_pos   = POS_W'(PAGE_SHIFT) + POS_W'($countones(lk_msk));
      lk_half    = lk_va[half_pos];
      off_mask   = ~({VA_W{1'b1}} << half_pos);
      lk_pfn     = t_pfn[lk_idx][lk_half];
      lk_vld     = t_v[lk_idx][lk_half];
      lk_hit_now = lk_found & lk_vld;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_invalid  <= 1'b0;
         rsp_tag_miss <= 1'b0;
         rsp_pa       <= '0;
         rsp_cattr    <= '0;
         rsp_dirty    <= 1'b0;
         rsp_uncached <= 1'b0;
      end else begin
         rsp_valid    <= lk_valid;
         rsp_hit      <= lk_valid & lk_hit_now;
         rsp_invalid  <= lk_valid & lk_found & ~lk_vld;
         rsp_tag_miss <= lk_valid & ~lk_found;
         if (lk_valid) begin
            rsp_pa       <= PA_W'({lk_pfn, {PAGE_SHIFT{1'b0}}}) | PA_W'(lk_va & off_mask);
            rsp_cattr    <= t_c[lk_idx][lk_half];
            rsp_dirty    <= t_d[lk_idx][lk_half];
            rsp_uncached <= (lk_va & UC_PATTERN) == UC_PATTERN;
         end
      end
   end

   tlb_stats #(.CNT_W(CNT_W)) u_stats (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_valid(lk_valid),
      .ev_write(lk_write),
      .ev_hit  (lk_hit_now),
      .sel     (stat_sel),
      .cnt     (stat_count)
   );

   // ---------------- assertions ----------------
   // R12
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   // R12
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);
   // R8
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot({rsp_hit, rsp_invalid, rsp_tag_miss}));
   // R3
   lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_found |-> (lk_match[lk_idx] &&
                    ((lk_match & ((ENTRIES)'(1) << lk_idx) - (ENTRIES)'(1)) == '0)));
   // R4
   probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_index == '1) || (pr_index < ENTRIES_V));
   // R5
   bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && !(wr_index < ENTRIES_V)) |=> $stable(t_used) && $stable(t_g));
   // R9
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (t_used == '0));
endmodule

// File: tb/test_asid_tlb.sv
`timescale 1ns/1ps
module test_asid_tlb;
   localparam int ENT   = 8;
   localparam int VPN_W = 19;
   localparam int ASW   = 8;
   localparam int PFN_W = 20;
   localparam int IW    = 4;
   localparam int CW    = 8;
   localparam logic [IW-1:0] NONE = 4'hF;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               lk_valid = 1'b0, lk_write = 1'b0;
   logic [31:0]        lk_va = '0;
   logic [ASW-1:0]     lk_asid = '0;
   logic               rsp_valid, rsp_hit, rsp_invalid, rsp_tag_miss;
   logic [29:0]        rsp_pa;
   logic [2:0]         rsp_cattr;
   logic               rsp_dirty, rsp_uncached;
   logic [VPN_W-1:0]   pr_vpn = '0;
   logic [ASW-1:0]     pr_asid = '0;
   logic [IW-1:0]      pr_index;
   logic               wr_en = 1'b0;
   logic [IW-1:0]      wr_index = '0;
   logic [29:0]        wr_hi = '0, wr_mask = '0;
   logic [25:0]        wr_lo0 = '0, wr_lo1 = '0;
   logic               flush = 1'b0;
   logic [1:0]         stat_sel = '0;
   logic [CW-1:0]      stat_count;

   always #4 clk = ~clk;

   asid_tlb #(.ENTRIES(ENT), .CNT_W(CW)) i_asid_tlb (
      .clk, .rst_n, .lk_valid, .lk_write, .lk_va, .lk_asid,
      .rsp_valid, .rsp_hit, .rsp_invalid, .rsp_tag_miss, .rsp_pa,
      .rsp_cattr, .rsp_dirty, .rsp_uncached, .pr_vpn, .pr_asid, .pr_index,
      .wr_en, .wr_index, .wr_hi, .wr_mask, .wr_lo0, .wr_lo1, .flush,
      .stat_sel, .stat_count);

   int n_chk = 0, n_fail = 0;
   int e_cnt [4] = '{0, 0, 0, 0};

   typedef struct {
      int          kind;   // 0 hit, 1 invalid half, 2 tag miss
      logic [29:0] pa;
      logic [2:0]  c;
      logic        d;
      logic        uc;
      string       req;
   } exp_t;
   exp_t sb[$];

   function automatic void chk(input bit ok, input string req, input string what,
                               input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endfunction

   function automatic logic [29:0] mk_hi(input logic [VPN_W-1:0] v, input logic [ASW-1:0] a);
      return (30'(v) << 11) | 30'(a);
   endfunction
   function automatic logic [25:0] mk_lo(input logic [19:0] pfn, input logic [2:0] c,
                                         input bit d, input bit v, input bit g);
      return (26'(pfn) << 6) | (26'(c) << 3) | (26'(d) << 2) | (26'(v) << 1) | 26'(g);
   endfunction

   task automatic wr(input int idx, input logic [29:0] hi, input logic [VPN_W-1:0] m,
                     input logic [25:0] l0, input logic [25:0] l1);
      @(negedge clk);
      wr_en = 1'b1; wr_index = IW'(idx); wr_hi = hi; wr_mask = 30'(m) << 11;
      wr_lo0 = l0; wr_lo1 = l1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // driver: issues one lookup and pushes the expected outcome
   task automatic lookup(input logic [31:0] va, input logic [ASW-1:0] asid, input bit w,
                         input int kind, input logic [29:0] pa, input logic [2:0] c,
                         input bit d, input bit uc, input string req);
      exp_t x;
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_write = w;
      x.kind = kind; x.pa = pa; x.c = c; x.d = d; x.uc = uc; x.req = req;
      sb.push_back(x);
      e_cnt[{w, kind != 0}]++;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      lk_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic probe(input logic [VPN_W-1:0] v, input logic [ASW-1:0] a,
                        input logic [IW-1:0] exp, input string req);
      @(negedge clk);
      pr_vpn = v; pr_asid = a;
      #1;
      chk(pr_index == exp, req, "probe index", pr_index, exp);
   endtask

   // monitor: pops the scoreboard as results appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R12", "response with nothing outstanding", 1, 0);
         end else begin
            exp_t x;
            int   ak;
            x  = sb.pop_front();
            ak = rsp_hit ? 0 : rsp_invalid ? 1 : rsp_tag_miss ? 2 : 3;
            chk(ak == x.kind, x.req, "outcome", ak, x.kind);
            chk(rsp_uncached == x.uc, x.req, "uncached (R10)", rsp_uncached, x.uc);
            if (x.kind == 0) begin
               chk(rsp_pa == x.pa, x.req, "pa", rsp_pa, x.pa);
               chk(rsp_cattr == x.c && rsp_dirty == x.d, x.req, "attr/dirty",
                   {rsp_cattr, rsp_dirty}, {x.c, x.d});
            end
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12: reset state
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", rsp_valid, 0);
      for (int s = 0; s < 4; s++) begin
         stat_sel = 2'(s); #1;
         chk(stat_count == 0, "R12", "counter after reset", stat_count, 0);
      end
      probe(19'h100, 8'd5, NONE, "R4 empty table");

      // slot 0: even half valid, odd half invalid
      wr(0, mk_hi(19'h100, 8'd5), '0, mk_lo(20'h111, 3'd2, 1, 1, 0), mk_lo(20'h222, 3'd3, 0, 0, 0));
      // slot 1: global in both halves
      wr(1, mk_hi(19'h200, 8'd9), '0, mk_lo(20'h10, 3'd0, 0, 1, 1), mk_lo(20'h333, 3'd5, 0, 1, 1));
      // slot 2: global only in even half -> not global
      wr(2, mk_hi(19'h300, 8'd1), '0, mk_lo(20'h30, 3'd1, 0, 1, 1), mk_lo(20'h31, 3'd1, 0, 1, 0));
      // slot 3: mask of two bits -> 4 KB pages, half chosen by va[12]
      wr(3, mk_hi(19'h404, 8'd4), 19'h3, mk_lo(20'h1000, 3'd1, 0, 1, 0), mk_lo(20'h2000, 3'd4, 1, 1, 0));
      // slots 5 and 4 share a tag
      wr(5, mk_hi(19'h500, 8'd3), '0, mk_lo(20'h55, 3'd0, 0, 1, 0), '0);
      wr(4, mk_hi(19'h500, 8'd3), '0, mk_lo(20'h44, 3'd6, 0, 1, 0), '0);
      // slot 6: page number with bit 18 set, reachable in the uncached window
      wr(6, mk_hi(19'h40010, 8'd0), '0, mk_lo(20'h66, 3'd2, 0, 1, 0), '0);

      // back-to-back lookups (R12)
      lookup(32'h0008_02A5, 8'd5, 0, 0, 30'h446A5, 3'd2, 1, 0, "R6 even half");
      lookup(32'h0008_0412, 8'd5, 0, 1, '0, '0, 0, 0, "R8 invalid half");
      lookup(32'h0008_02A5, 8'd6, 0, 2, '0, '0, 0, 0, "R2 asid mismatch");
      lookup(32'h0010_0403, 8'h77, 1, 0, 30'hCCC03, 3'd5, 0, 0, "R2 global odd half");
      lookup(32'h0018_0000, 8'd2, 1, 2, '0, '0, 0, 0, "R6 one-sided global");
      lookup(32'h0018_0000, 8'd1, 0, 0, 30'h0C000, 3'd1, 0, 0, "R2 asid match");
      lookup(32'h0020_3123, 8'd4, 0, 0, 30'h800123, 3'd4, 1, 0, "R1 R7 masked odd");
      lookup(32'h0020_2005, 8'd4, 0, 0, 30'h400005, 3'd1, 0, 0, "R7 masked even");
      lookup(32'h0020_4000, 8'd4, 0, 2, '0, '0, 0, 0, "R1 unmasked bit differs");
      lookup(32'h0028_0007, 8'd3, 0, 0, 30'h11007, 3'd6, 0, 0, "R3 lowest index");
      lookup(32'hA000_8000, 8'd0, 0, 0, 30'h19800, 3'd2, 0, 1, "R10 hit uncached");
      lookup(32'hE000_0000, 8'd0, 1, 2, '0, '0, 0, 1, "R10 miss uncached");
      idle(3);
      chk(sb.size() == 0, "R12", "responses outstanding", sb.size(), 0);

      probe(19'h100, 8'd5, 4'd0, "R4 invalid half still tag-matches");
      probe(19'h100, 8'd6, NONE, "R4 no match");
      probe(19'h406, 8'd4, 4'd3, "R4 masked");
      probe(19'h500, 8'd3, 4'd4, "R3 probe lowest");
      probe(19'h200, 8'h55, 4'd1, "R4 global");

      // R5: index 8 is one past the end
      wr(8, mk_hi(19'h700, 8'd0), '0, mk_lo(20'h77, 3'd0, 0, 1, 0), '0);
      probe(19'h700, 8'd0, NONE, "R5 out-of-range write ignored");
      probe(19'h100, 8'd5, 4'd0, "R5 slot 0 untouched");
      wr(7, mk_hi(19'h700, 8'd0), '0, mk_lo(20'h77, 3'd0, 0, 1, 0), '0);
      probe(19'h700, 8'd0, 4'd7, "R5 last slot writable");

      // R11: counters
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         stat_sel = 2'(s); #1;
         chk(stat_count == CW'(e_cnt[s]), "R11", $sformatf("counter %0d", s), stat_count, e_cnt[s]);
      end

      // R9: flush, with a write in the same cycle losing
      @(negedge clk);
      flush = 1'b1; wr_en = 1'b1; wr_index = 4'd2; wr_hi = mk_hi(19'h123, 8'd0);
      wr_mask = '0; wr_lo0 = mk_lo(20'h1, 3'd0, 0, 1, 0);
      @(negedge clk);
      flush = 1'b0; wr_en = 1'b0;
      probe(19'h100, 8'd5, NONE, "R9 flushed slot 0");
      probe(19'h123, 8'd0, NONE, "R9 flush beats write");
      probe(19'h700, 8'd0, NONE, "R9 flushed slot 7");
      lookup(32'h0008_02A5, 8'd5, 0, 2, '0, '0, 0, 0, "R9 lookup after flush");
      idle(3);
      stat_sel = 2'd1; #1;
      chk(stat_count == CW'(e_cnt[1]), "R11", "flush keeps counters", stat_count, e_cnt[1]);
      finish_run();
   end
endmodule